// File: doc/BRIEF.md
# SRAM Power-Up Initialization Sequencer

This block takes a DDR-II style synchronous SRAM from cold power to normal operation in a safe order. Once reset is released it turns on the core rail and waits for that rail's power-good report. It then turns on the I/O rail and waits again. The reference voltage comes after that. While all this happens the DLL-run control stays low. The DLL is released only when every rail reports good and the memory input clock is flagged stable.

With the DLL running, the sequencer counts consecutive stable clock cycles. After `LOCK_CYCLES` of them (1024 by default) it raises `ready`. If the clock-stable flag drops at any point, the count starts again from zero. In the ready state a drop also withdraws `ready` until a full new lock wait has finished.

Each rail stage has a watchdog of `TIMEOUT_CYCLES`. If a power-good input fails to arrive in that time, a sticky error flag is set and the sequencer freezes where it is. Only reset releases it. Every asynchronous status input passes through a two-flop synchronizer before the state machine uses it.

Top module: `sram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `core_en`, `io_en`, `ref_en`, `dll_run`, `ready` and `timeout_err` are all 0.
- R2: `io_en` never goes high while `core_en` is low, and it rises only after `core_pg` has been seen high.
- R3: `ref_en` is never high while `io_en` is low. It rises one cycle after `io_en` when `io_pg` is already high.
- R4: `dll_run` stays low until all three power-good inputs and `clk_stable` are seen high. It never goes high while `ref_en` is low.
- R5: When `clk_stable` is held high, `ready` rises exactly `LOCK_CYCLES`+1 cycles after `dll_run` rises. `ready` is never high while `dll_run` is low.
- R6: A low on `clk_stable` of any length (even one cycle) clears the lock count. If `ready` is high, it falls on the third clock edge after the drop. After `clk_stable` returns high, `ready` rises exactly `LOCK_CYCLES`+3 edges later. A return that lasts only `LOCK_CYCLES`-1 edges before the next drop does not produce `ready`.
- R7: If a rail's power-good is not seen within `TIMEOUT_CYCLES` of the stage starting, `timeout_err` is set. It stays set until reset, and no enable output changes while it is set, even if the power-good arrives later.
- R8: Every status input has a two-flop synchronizer in front of the state machine. A power-good that goes high before a clock edge has its effect on the outputs after the third edge, and not before.
- R9: A power-good input for a later stage that goes high early has no effect until every earlier stage has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (memory clock domain) |
| rst | input | 1 | Synchronous reset, active high |
| core_pg | input | 1 | Core rail power-good, asynchronous |
| io_pg | input | 1 | I/O rail power-good, asynchronous |
| ref_pg | input | 1 | Reference voltage power-good, asynchronous |
| clk_stable | input | 1 | Memory input clock reported stable, asynchronous |
| core_en | output | 1 | Core rail enable |
| io_en | output | 1 | I/O rail enable |
| ref_en | output | 1 | Reference voltage enable |
| dll_run | output | 1 | DLL-run control; low keeps the memory DLL off |
| ready | output | 1 | Memory may start normal operation |
| timeout_err | output | 1 | Sticky rail power-good timeout |

## Verification
The assertions assume that reset is high at the first clock edge. They also assume that every status input stays at one level between edges, so each change is seen through the synchronizers as a clean step. The bench holds reset from time zero and drives every input on the falling edge only. Power-good inputs rise once per run and are only cleared under reset, so rail ordering is never asked to handle a rail that drops out. Only `clk_stable` is toggled while the sequencer is running.

// File: rtl/sram_pwrup_pkg.sv
package sram_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_CORE    = 3'd1,
    ST_IO      = 3'd2,
    ST_REF     = 3'd3,
    ST_CLKWAIT = 3'd4,
    ST_LOCK    = 3'd5,
    ST_RUN     = 3'd6
  } seq_state_t;

  // Bits needed to hold the values 0..n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // An output whose first active stage is 'first' stays on from there onward.
  function automatic logic stage_reached(input seq_state_t s, input seq_state_t first);
    return (s >= first);
  endfunction

  // True in the three stages that wait for a rail power-good.
  function automatic logic is_rail_stage(input seq_state_t s);
    return (s == ST_CORE) || (s == ST_IO) || (s == ST_REF);
  endfunction

  // Power-good that belongs to the stage currently waiting.
  function automatic logic stage_pg(input seq_state_t s, input logic [2:0] pg);
    case (s)
      ST_CORE: return pg[0];
      ST_IO:   return pg[1];
      ST_REF:  return pg[2];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sram_pwrup_sync.sv
module sram_pwrup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic expire
);
  import sram_pwrup_pkg::*;
  localparam int unsigned TW = cnt_bits(TIMEOUT_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !waiting) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = waiting && (cnt == LAST);
endmodule

// File: rtl/sram_pwrup_lock.sv
module sram_pwrup_lock #(
  parameter int unsigned LOCK_CYCLES = 1024,
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          clk_ok,
  output logic [CW-1:0] count,
  output logic          done
);
  localparam logic [CW-1:0] TARGET = CW'(LOCK_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || !active || !clk_ok) count <= '0;
    else if (count != TARGET)      count <= count + 1'b1;
  end

  assign done = (count == TARGET);
endmodule

// File: rtl/sram_pwrup_seq.sv
module sram_pwrup_seq #(
  parameter int unsigned LOCK_CYCLES    = 1024,
  parameter int unsigned TIMEOUT_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic core_pg,
  input  logic io_pg,
  input  logic ref_pg,
  input  logic clk_stable,
  output logic core_en,
  output logic io_en,
  output logic ref_en,
  output logic dll_run,
  output logic ready,
  output logic timeout_err
);
  import sram_pwrup_pkg::*;
  localparam int unsigned LCW = cnt_bits(LOCK_CYCLES);

  seq_state_t state, state_nx;

  // Synchronized status
  logic [3:0] raw_in, sync_out;
  logic       core_pg_s, io_pg_s, ref_pg_s, clk_ok_s;

  assign raw_in = {clk_stable, ref_pg, io_pg, core_pg};

  sram_pwrup_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (sync_out)
  );

  assign {clk_ok_s, ref_pg_s, io_pg_s, core_pg_s} = sync_out;

  // Named internal events
  logic             rail_waiting;
  logic             timer_expire;
  logic             lock_active;
  logic             lock_done;
  logic [LCW-1:0]   lock_cnt;
  logic             supplies_good;
  logic             clk_lost;

  assign rail_waiting  = is_rail_stage(state) && !timeout_err &&
                         !stage_pg(state, {ref_pg_s, io_pg_s, core_pg_s});
  assign lock_active   = (state == ST_LOCK) || (state == ST_RUN);
  assign supplies_good = core_pg_s && io_pg_s && ref_pg_s;
  assign clk_lost      = (state == ST_RUN) && !clk_ok_s;

  sram_pwrup_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .waiting (rail_waiting),
    .expire  (timer_expire)
  );

  sram_pwrup_lock #(.LOCK_CYCLES(LOCK_CYCLES), .CW(LCW)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .active (lock_active),
    .clk_ok (clk_ok_s),
    .count  (lock_cnt),
    .done   (lock_done)
  );

  // Sticky timeout flag
  always_ff @(posedge clk) begin
    if (rst)               timeout_err <= 1'b0;
    else if (timer_expire) timeout_err <= 1'b1;
  end

  // Next-state logic
  always_comb begin
    state_nx = state;
    if (!timeout_err) begin
      case (state)
        ST_OFF:     state_nx = ST_CORE;
        ST_CORE:    if (core_pg_s) state_nx = ST_IO;
        ST_IO:      if (io_pg_s)   state_nx = ST_REF;
        ST_REF:     if (ref_pg_s)  state_nx = ST_CLKWAIT;
        ST_CLKWAIT: if (supplies_good && clk_ok_s) state_nx = ST_LOCK;
        ST_LOCK:    if (lock_done && clk_ok_s)     state_nx = ST_RUN;
        ST_RUN:     if (clk_lost)                  state_nx = ST_LOCK;
        default:    state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= state_nx;
  end

  // Output decode from the state register
  assign core_en = stage_reached(state, ST_CORE);
  assign io_en   = stage_reached(state, ST_IO);
  assign ref_en  = stage_reached(state, ST_REF);
  assign dll_run = stage_reached(state, ST_LOCK);
  assign ready   = (state == ST_RUN);

endmodule

// File: rtl/sram_pwrup_chk.sv
module sram_pwrup_chk #(
  parameter int unsigned LOCK_CYCLES = 1024,
  parameter int unsigned LCW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           core_en,
  input logic           io_en,
  input logic           ref_en,
  input logic           dll_run,
  input logic           ready,
  input logic           timeout_err,
  input logic           core_pg_s,
  input logic           clk_ok_s,
  input logic [LCW-1:0] lock_cnt
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!core_en && !io_en && !ref_en && !dll_run && !ready && !timeout_err));

  assert_io_needs_core_R2: assert property (@(posedge clk) disable iff (rst)
    io_en |-> core_en);

  assert_ref_needs_io_R3: assert property (@(posedge clk) disable iff (rst)
    ref_en |-> io_en);

  assert_dll_needs_ref_R4: assert property (@(posedge clk) disable iff (rst)
    dll_run |-> ref_en);

  assert_dll_after_clk_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_run) |-> $past(clk_ok_s));

  assert_ready_needs_dll_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> dll_run);

  assert_ready_full_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(lock_cnt) == LCW'(LOCK_CYCLES)));

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && !clk_ok_s) |=> !ready);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);

  assert_err_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> $stable({core_en, io_en, ref_en, dll_run, ready}));

  assert_io_after_sync_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(io_en) |-> $past(core_pg_s));

endmodule

bind sram_pwrup_seq sram_pwrup_chk #(.LOCK_CYCLES(LOCK_CYCLES), .LCW(LCW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_en     (core_en),
  .io_en       (io_en),
  .ref_en      (ref_en),
  .dll_run     (dll_run),
  .ready       (ready),
  .timeout_err (timeout_err),
  .core_pg_s   (core_pg_s),
  .clk_ok_s    (clk_ok_s),
  .lock_cnt    (lock_cnt)
);

// File: tb/test_sram_pwrup_seq.sv
`timescale 1ns/1ps
module test_sram_pwrup_seq;
  localparam int LOCK = 1024;
  localparam int TMO  = 200;
  localparam int NVEC = 4;
  // Each row: first low length (>=3), high run before a second drop (0 = none), second low length
  localparam int VEC [NVEC][3] = '{
    '{3, 0,    0},
    '{5, 300,  1},
    '{4, 1023, 2},
    '{8, 600,  7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_pg = 1'b0, io_pg = 1'b0, ref_pg = 1'b0, clk_stable = 1'b0;
  logic core_en, io_en, ref_en, dll_run, ready, timeout_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_pwrup_seq #(.LOCK_CYCLES(LOCK), .TIMEOUT_CYCLES(TMO)) i_sram_pwrup_seq (
    .clk(clk), .rst(rst), .core_pg(core_pg), .io_pg(io_pg), .ref_pg(ref_pg),
    .clk_stable(clk_stable), .core_en(core_en), .io_en(io_en), .ref_en(ref_en),
    .dll_run(dll_run), .ready(ready), .timeout_err(timeout_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] outs();
    return {core_en, io_en, ref_en, dll_run, ready, timeout_err};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    edges(4);
    check("R1 outputs in reset", 32'(outs()), 32'h0);
    rst = 1'b0;
    edges(1);
    check("R1 core_en on after reset", 32'(outs()), 32'h20);

    // R9: early io_pg has no effect before core stage completes
    io_pg = 1'b1;
    edges(10);
    check("R9 io_en stays low with early io_pg", 32'(io_en), 32'h0);
    check("R2 core_en held", 32'(core_en), 32'h1);

    // R8 / R2: core_pg acts after third edge
    core_pg = 1'b1;
    edges(2);
    check("R8 io_en low two edges after core_pg", 32'(io_en), 32'h0);
    edges(1);
    check("R8 io_en high three edges after core_pg", 32'(io_en), 32'h1);
    check("R3 ref_en not yet on", 32'(ref_en), 32'h0);
    edges(1);
    check("R3 ref_en one cycle after io_en", 32'(ref_en), 32'h1);

    // R4: DLL held off until supplies and clock are good
    ref_pg = 1'b1;
    edges(20);
    check("R4 dll_run low without clk_stable", 32'(dll_run), 32'h0);
    clk_stable = 1'b1;
    edges(2);
    check("R4 dll_run low two edges after clk_stable", 32'(dll_run), 32'h0);
    edges(1);
    check("R4 dll_run high three edges after clk_stable", 32'(dll_run), 32'h1);

    // R5: lock wait length
    edges(LOCK);
    check("R5 ready low one cycle before lock", 32'(ready), 32'h0);
    edges(1);
    check("R5 ready after LOCK+1 cycles", 32'(ready), 32'h1);

    // R6: table of clock-stability disturbances
    for (int v = 0; v < NVEC; v++) begin
      clk_stable = 1'b0;
      for (int k = 1; k <= VEC[v][0]; k++) begin
        @(negedge clk);
        if (k == 3) check($sformatf("R6 ready withdrawn vec %0d", v), 32'(ready), 32'h0);
        if (k == VEC[v][0]) clk_stable = 1'b1;
      end
      if (VEC[v][1] > 0) begin
        edges(VEC[v][1]);
        clk_stable = 1'b0;
        edges(VEC[v][2]);
        clk_stable = 1'b1;
      end
      edges(LOCK + 2);
      check($sformatf("R6 ready low before relock vec %0d", v), 32'(ready), 32'h0);
      edges(1);
      check($sformatf("R6 ready after relock vec %0d", v), 32'(ready), 32'h1);
      check($sformatf("R5 dll_run with ready vec %0d", v), 32'(dll_run), 32'h1);
    end

    // R7: rail timeout, sticky and freezing
    rst = 1'b1;
    core_pg = 1'b0; io_pg = 1'b0; ref_pg = 1'b0; clk_stable = 1'b0;
    edges(3);
    check("R1 outputs cleared by reset", 32'(outs()), 32'h0);
    rst = 1'b0;
    edges(150);
    check("R7 no timeout before limit", 32'(timeout_err), 32'h0);
    edges(100);
    check("R7 timeout after limit", 32'(timeout_err), 32'h1);
    core_pg = 1'b1;
    edges(20);
    check("R7 frozen despite late core_pg", 32'(outs()), 32'h21);
    rst = 1'b1;
    edges(2);
    check("R1 reset clears timeout", 32'(outs()), 32'h0);
    rst = 1'b0;
    edges(5);
    check("R2 sequence resumes after reset", 32'(io_en), 32'h1);

    finish_run();
  end
endmodule